// File: doc/BRIEF.md
# Piecewise-Linear Sine Amplitude Generator

This block is the digital core of a direct digital frequency synthesizer. A phase accumulator adds a frequency tuning word on every enabled clock. The top twelve bits of the phase are folded onto a quarter wave. A 32-entry segment table then supplies a base level and a slope for the current segment, and the block turns these into one signed 12-bit amplitude sample per clock.

The block has no multiplier and stores no per-sample waveform. The slope is applied to the position inside the segment by an array of AND-gated fixed weights. Each weight stands for one gain-bit and position-bit pair. Fractional pairs are rounded to a whole unit or dropped, following a fixed pattern. The table is written through a simple write port, normally while reset is held, and its contents are chosen by the user.

Top module: `pwl_sine_gen`

## Requirements
- R1: A synchronous reset clears the phase and every pipeline stage, and `amp` reads 0 after the first clock edge that sees `rst` high.
- R2: On each clock edge with `en` high and `rst` low, the 24-bit phase grows by `ftw` modulo 2^24.
- R3: With `en` low, the phase keeps its value, so after the pipeline drains `amp` stays constant.
- R4: Let p be phase bits [23:12]. When p[10] is 1, the ten bits p[9:0] are inverted bitwise before use. When p[10] is 0, they are used as they are.
- R5: Of the ten folded bits, bits [9:5] pick the segment index and bits [4:0] give the unsigned in-segment position x.
- R6: A clock edge with `tbl_we` high stores `tbl_off` (11 bits) and `tbl_gain` (6 bits) as entry `tbl_idx`. Each entry is 17 bits and there are 32 entries.
- R7: The linear term is a sum of weights. A weight is added for each gain bit i (0..5) and position bit j (0..4) that are both 1. The exact value of the pair is 2^(i+j-5). A value of 1 or more is added as it is, a value of exactly 1/2 adds 1, and anything smaller adds nothing. The array also has a sixth, top position column (exact value 2^i). That column is driven by a sign position bit, which is always 0 for folded phases.
- R8: The magnitude is the segment base level plus the linear term, clamped to 2047.
- R9: `amp` is two's complement. Phase bit p[11] = 0 gives +magnitude and p[11] = 1 gives -magnitude, so the code 12'h800 never appears.
- R10: A phase value that the accumulator takes at clock edge k sets `amp` at edge k+3, and a new sample leaves on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Phase advance enable |
| ftw | input | 24 | Frequency tuning word |
| tbl_we | input | 1 | Segment table write strobe |
| tbl_idx | input | 5 | Segment index to write |
| tbl_off | input | 11 | Segment base level |
| tbl_gain | input | 6 | Segment slope |
| amp | output | 12 | Signed amplitude sample |

## Verification
The phase register updates on the edge that samples `en` and `ftw`. The amplitude for that phase appears on `amp` three edges later: one edge for the table lookup, one for the clamped sum and one for the signed result. The scoreboard keeps a phase model that advances with the same input values the design sampled. At every falling edge it pushes the expected sample for the current phase, and it compares a sample only once four items are queued, which is exactly the three-edge delay. A reset edge empties the queue, and the reset value is checked directly at the port while reset is held.

// File: rtl/pwl_sine_gen.sv
module pwl_sine_gen #(
  parameter int PW     = 24,
  parameter int SEG_W  = 5,
  parameter int POS_W  = 5,
  parameter int OFF_W  = 11,
  parameter int GAIN_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PW-1:0]     ftw,
  input  logic              tbl_we,
  input  logic [SEG_W-1:0]  tbl_idx,
  input  logic [OFF_W-1:0]  tbl_off,
  input  logic [GAIN_W-1:0] tbl_gain,
  output logic [OFF_W:0]    amp
);
  localparam int FOLD_W = SEG_W + POS_W;
  localparam int PH_W   = FOLD_W + 2;
  localparam int NSEG   = 1 << SEG_W;
  localparam int COLS   = POS_W + 1;
  localparam int SUM_W  = OFF_W + 2;
  localparam logic [SUM_W-1:0] MAXMAG = SUM_W'((1 << OFF_W) - 1);

  function automatic int wt(int i, int c);
    int e;
    e = i + c - POS_W;
    if (e >= 0) return 1 << e;
    else if (e == -1) return 1;
    else return 0;
  endfunction

  logic [PW-1:0] acc;
  always_ff @(posedge clk)
    if (rst) acc <= '0;
    else if (en) acc <= acc + ftw;

  wire [PH_W-1:0]   ph   = acc[PW-1 -: PH_W];
  wire [FOLD_W-1:0] fold = ph[FOLD_W] ? ~ph[FOLD_W-1:0] : ph[FOLD_W-1:0];

  logic [OFF_W-1:0]  off_mem  [NSEG];
  logic [GAIN_W-1:0] gain_mem [NSEG];
  always_ff @(posedge clk)
    if (tbl_we) begin
      off_mem[tbl_idx]  <= tbl_off;
      gain_mem[tbl_idx] <= tbl_gain;
    end

  logic [OFF_W-1:0]  s1_off;
  logic [GAIN_W-1:0] s1_gain;
  logic [POS_W-1:0]  s1_pos;
  logic              s1_sgn;
  always_ff @(posedge clk)
    if (rst) begin
      s1_off <= '0; s1_gain <= '0; s1_pos <= '0; s1_sgn <= 1'b0;
    end else begin
      s1_off  <= off_mem[fold[FOLD_W-1:POS_W]];
      s1_gain <= gain_mem[fold[FOLD_W-1:POS_W]];
      s1_pos  <= fold[POS_W-1:0];
      s1_sgn  <= ph[PH_W-1];
    end

  wire [COLS-1:0] col = {1'b0, s1_pos};
  logic [SUM_W-1:0] lin;
  always_comb begin
    lin = '0;
    for (int i = 0; i < GAIN_W; i++)
      for (int c = 0; c < COLS; c++)
        if (s1_gain[i] && col[c]) lin = lin + SUM_W'(wt(i, c));
  end

  wire [SUM_W-1:0] raw = {2'b00, s1_off} + lin;
  wire [OFF_W-1:0] sat = (raw > MAXMAG) ? MAXMAG[OFF_W-1:0] : raw[OFF_W-1:0];

  logic [OFF_W-1:0] mag_q;
  logic             s2_sgn;
  always_ff @(posedge clk)
    if (rst) begin
      mag_q <= '0; s2_sgn <= 1'b0;
    end else begin
      mag_q <= sat; s2_sgn <= s1_sgn;
    end

  logic [OFF_W:0] amp_q;
  always_ff @(posedge clk)
    if (rst) amp_q <= '0;
    else amp_q <= s2_sgn ? -{1'b0, mag_q} : {1'b0, mag_q};
  assign amp = amp_q;

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> amp == '0);
  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> acc == $past(acc) + $past(ftw));
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));
  p_table_write_r6: assert property (@(posedge clk)
    tbl_we |=> off_mem[$past(tbl_idx)] == $past(tbl_off) && gain_mem[$past(tbl_idx)] == $past(tbl_gain));
  p_sign_follow_r9: assert property (@(posedge clk) disable iff (rst)
    (amp != '0) |-> amp[OFF_W] == $past(acc[PW-1], 3));
  p_no_full_neg_r9: assert property (@(posedge clk) disable iff (rst)
    amp != {1'b1, {OFF_W{1'b0}}});
endmodule

// File: tb/pwl_sine_gen_bench.sv
`timescale 1ns/1ps
module pwl_sine_gen_bench;
  logic clk = 0, rst = 1, en = 0, tbl_we = 0;
  logic [23:0] ftw = '0;
  logic [4:0] tbl_idx = '0;
  logic [10:0] tbl_off = '0;
  logic [5:0] tbl_gain = '0;
  logic [11:0] amp;

  pwl_sine_gen u_pwl_sine_gen (.clk, .rst, .en, .ftw, .tbl_we, .tbl_idx,
                               .tbl_off, .tbl_gain, .amp);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  int m_off [32];
  int m_gain [32];
  string cur_tag = "R1";

  function automatic logic [11:0] exp_amp(logic [23:0] a);
    logic [11:0] p;
    logic [9:0] f;
    int seg, x, lin, mag;
    real term;
    p = a[23:12];
    f = p[10] ? ~p[9:0] : p[9:0];
    seg = int'(f[9:5]);
    x = int'(f[4:0]);
    lin = 0;
    for (int gi = 0; gi < 6; gi++)
      if (m_gain[seg][gi])
        for (int j = 0; j < 5; j++)
          if (x[j]) begin
            term = (2.0 ** gi) * (2.0 ** j) / 32.0;
            if (term >= 1.0) lin += int'(term);
            else if (term >= 0.5) lin += 1;
          end
    mag = m_off[seg] + lin;
    if (mag > 2047) mag = 2047;
    return p[11] ? 12'(-mag) : 12'(mag);
  endfunction

  logic [11:0] q_exp [$];
  string q_tag [$];
  logic rst_p = 1, en_p = 0;
  logic [23:0] ftw_p = '0, acc_m = '0;

  always @(negedge clk) begin
    if (rst_p) begin
      acc_m = '0;
      q_exp.delete();
      q_tag.delete();
    end else begin
      if (en_p) acc_m = acc_m + ftw_p;
      q_exp.push_back(exp_amp(acc_m));
      q_tag.push_back(cur_tag);
      if (q_exp.size() > 3) begin
        logic [11:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if (amp !== e) begin
          failures++;
          $display("FAIL [%s R10] amp=%0d expected=%0d", t, $signed(amp), $signed(e));
        end
      end
    end
    rst_p = rst; en_p = en; ftw_p = ftw;
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(int mode);
    for (int k = 0; k < 32; k++) begin
      real s0, s1, g;
      if (mode == 0) begin
        s0 = 2047.0 * $sin(k * 3.14159265358979 / 64.0);
        s1 = 2047.0 * $sin((k + 1) * 3.14159265358979 / 64.0);
        m_off[k] = int'(s0);
        g = (s1 - s0) * 32.0 / 31.0;
        m_gain[k] = (g > 63.0) ? 63 : int'(g);
      end else begin
        m_off[k] = (k % 4 == 0) ? 2047 - k : 60 * k;
        m_gain[k] = 2 * k + mode - 1;
      end
      tbl_we = 1; tbl_idx = 5'(k); tbl_off = 11'(m_off[k]); tbl_gain = 6'(m_gain[k]);
      step(1);
    end
    tbl_we = 0;
  endtask

  task automatic reset_and_load(int mode);
    rst = 1; en = 0; cur_tag = "R1";
    step(2);
    load(mode);
    step(1);
    @(negedge clk);
    checks++;
    if (amp !== 12'd0) begin
      failures++;
      $display("FAIL [R1] amp=%0d expected=0", $signed(amp));
    end
    step(1);
  endtask

  initial begin
    step(1);
    reset_and_load(0);
    rst = 0; en = 1; ftw = 24'd4096; cur_tag = "R4 R5 R6 R7 R9";
    step(4100);
    en = 0; cur_tag = "R3";
    step(30);
    en = 1; ftw = 24'h9E3779; cur_tag = "R2";
    step(500);
    for (int k = 0; k < 200; k++) begin
      en = k[0]; ftw = 24'(k * 7919 + 12345); cur_tag = "R2 R3";
      step(1);
    end
    en = 1; ftw = 24'hFFF000; cur_tag = "R2 R4";
    step(300);
    reset_and_load(1);
    rst = 0; en = 1; ftw = 24'd4096; cur_tag = "R7 R8";
    step(4100);
    reset_and_load(2);
    rst = 0; en = 1; ftw = 24'd4096; cur_tag = "R7 R8";
    step(4100);
    en = 0;
    step(6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(100000 * 5);
    failures++;
    $display("FAIL [watchdog] run=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule